// File: doc/BRIEF.md
# Prescaled PWM Contrast Generator

This block drives one pulse-width-modulated pin. An external low-pass filter turns that pin into an analog contrast level for a display panel. A single 32-bit configuration word sets three things: the active width, as an 8-bit compare value; the active level, as a polarity bit; and the step rate, as a 4-bit power-of-two prescaler code. The word sits on a plain register bus with write enable, address, write data and combinational read data. A lock input blocks every update while it is high.

Inside, a prescaler produces one step tick every 2^n clock cycles. An 8-bit counter advances on each tick and wraps after 256 steps. The output is active while the counter is below the compare value. The block keeps working copies of the three fields and refreshes them only when the counter wraps, so a reprogrammed value never cuts a period short. The prescaler also starts from zero at that boundary.

Top module: `pwm_contrast`

## Requirements
- R1: While reset (synchronous, active high) is asserted, pwm_out is 0. After a reset edge the configuration word is all zeros and a read returns 0.
- R2: The configuration word lives at address CFG_ADDR (default 0). Its layout is: compare value in bits 15:8, polarity in bit 4, prescaler code in bits 3:0. A read at that address returns these fields with zeros in all other bit positions. A read at any other address returns 0, and a write to any other address changes nothing.
- R3: A write issued while wr_lock is 1 leaves both the stored word and the output waveform unchanged.
- R4: With prescaler code n, the period counter advances once every 2^n clock cycles, for n from 0 (divide by 1) to 15 (divide by 32768).
- R5: The period counter is 8 bits wide and wraps from 255 to 0, so one output period is 256 steps. At code 0 that is 256 clock cycles.
- R6: With polarity 1, pwm_out is 1 while the counter is strictly below the compare value and 0 otherwise. Each period therefore has compare×2^n high cycles.
- R7: With polarity 0, the output is inverted. Each period has compare×2^n low cycles and is high for the rest.
- R8: A compare value of 0 holds pwm_out at the inactive level (0 for polarity 1, 1 for polarity 0) for the whole period. This covers the state just after reset.
- R9: A newly written word takes effect only at the next counter wrap. Until then the output keeps following the previous settings.
- R10: At the wrap that applies a new prescaler code, the prescaler starts from zero. The first step of the new period therefore lasts exactly 2^n clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from address |
| wr_lock | input | 1 | Blocks register writes while high |
| pwm_out | output | 1 | Contrast PWM output |

## Verification
A corrupted working copy or a wrong counter shows up at the pin as a wrong number of active cycles. Any window of exactly one period contains one whole period, so the bench counts active cycles over such a window, and an error becomes visible within one period of the setting being applied. A prescaler that fails to restart, or that divides wrongly, changes the measured width of the first active phase after a code change, even at divide by 32768. A write that leaks past the lock, or that is applied before the wrap, alters the read-back word at once or the waveform within the following period.

// File: rtl/pwm_contrast_pkg.sv
package pwm_contrast_pkg;

    localparam int CMP_W   = 8;
    localparam int PS_W    = 4;
    localparam int CMP_LSB = 8;
    localparam int POL_BIT = 4;
    localparam int PS_LSB  = 0;

    typedef struct packed {
        logic [CMP_W-1:0] cmp;
        logic             pol;
        logic [PS_W-1:0]  ps;
    } pwm_cfg_t;

endpackage

// File: rtl/pwm_cfg_reg.sv
module pwm_cfg_reg
    import pwm_contrast_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] CFG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lock,
    output pwm_cfg_t          cfg,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        pwm_cfg_t cfg;
    } reg_state_t;

    reg_state_t s_d, s_q;
    logic       hit;
    logic       unused_wdata;

    assign hit          = (addr == CFG_ADDR);
    assign unused_wdata = ^wdata;

    always_comb begin
        s_d = s_q;
        if (we && !lock && hit) begin
            s_d.cfg.cmp = wdata[CMP_LSB +: CMP_W];
            s_d.cfg.pol = wdata[POL_BIT];
            s_d.cfg.ps  = wdata[PS_LSB +: PS_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cfg = s_q.cfg;

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[CMP_LSB +: CMP_W] = s_q.cfg.cmp;
            rdata[POL_BIT]          = s_q.cfg.pol;
            rdata[PS_LSB +: PS_W]   = s_q.cfg.ps;
        end
    end

    AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (we && lock) |=> $stable(cfg)); // R3

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_contrast_pkg::*;
#(
    parameter int SEL_W = PS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int DIV_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] pre;
    } pre_state_t;

    pre_state_t       s_d, s_q;
    logic [DIV_W-1:0] limit;

    assign limit = ~({DIV_W{1'b1}} << sel);
    assign tick  = (s_q.pre == limit);

    always_comb begin
        s_d = s_q;
        if (tick) s_d.pre = '0;
        else      s_d.pre = s_q.pre + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        s_q.pre <= limit); // R4

endmodule

// File: rtl/pwm_period.sv
module pwm_period
    import pwm_contrast_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  pwm_cfg_t        cfg,
    output logic [PS_W-1:0] act_ps,
    output logic            level
);

    typedef struct packed {
        logic [CMP_W-1:0] cnt;
        pwm_cfg_t         act;
        logic             run;
    } per_state_t;

    per_state_t s_d, s_q;
    logic       wrap;
    logic       below;

    assign wrap  = tick && (s_q.cnt == {CMP_W{1'b1}});
    assign below = (s_q.cnt < s_q.act.cmp);

    always_comb begin
        s_d     = s_q;
        s_d.run = 1'b1;
        if (tick) s_d.cnt = s_q.cnt + 1'b1;
        if (wrap) s_d.act = cfg;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign act_ps = s_q.act.ps;
    assign level  = s_q.run && (s_q.act.pol ? below : !below);

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(s_q.cnt)); // R4
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && s_q.cnt != {CMP_W{1'b1}}) |=> s_q.cnt == CMP_W'($past(s_q.cnt) + 1)); // R5
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        wrap |=> s_q.cnt == '0); // R5
    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(s_q.act)); // R9

endmodule

// File: rtl/pwm_contrast.sv
module pwm_contrast
    import pwm_contrast_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] CFG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              wr_lock,
    output logic              pwm_out
);

    pwm_cfg_t        cfg;
    logic [PS_W-1:0] act_ps;
    logic            tick;

    pwm_cfg_reg #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CFG_ADDR(CFG_ADDR)
    ) u_cfg (
        .clk  (clk),
        .rst  (rst),
        .we   (reg_we),
        .addr (reg_addr),
        .wdata(reg_wdata),
        .lock (wr_lock),
        .cfg  (cfg),
        .rdata(reg_rdata)
    );

    pwm_prescaler #(
        .SEL_W(PS_W)
    ) u_pre (
        .clk (clk),
        .rst (rst),
        .sel (act_ps),
        .tick(tick)
    );

    pwm_period u_per (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .cfg   (cfg),
        .act_ps(act_ps),
        .level (pwm_out)
    );

    AST_RST_LOW: assert property (@(posedge clk)
        rst |=> !pwm_out); // R1

endmodule

// File: tb/pwm_contrast_bench.sv
`timescale 1ns/1ps
module pwm_contrast_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wr_lock = 1'b0;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pwm_contrast u_pwm_contrast (
        .clk      (clk),
        .rst      (rst),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .wr_lock  (wr_lock),
        .pwm_out  (pwm_out)
    );

    // {cmp[31:24], pol[20], ps[19:16], expected high cycles per period[15:0]}
    localparam logic [31:0] VEC [8] = '{
        32'h4010_0040,  // cmp 64,  pol 1, ps 0 -> 64 of 256
        32'h4000_00C0,  // cmp 64,  pol 0, ps 0 -> 192 of 256
        32'h0010_0000,  // cmp 0,   pol 1, ps 0 -> 0
        32'h0000_0100,  // cmp 0,   pol 0, ps 0 -> 256
        32'hFF10_00FF,  // cmp 255, pol 1, ps 0 -> 255
        32'h8011_0100,  // cmp 128, pol 1, ps 1 -> 256 of 512
        32'h0A02_03D8,  // cmp 10,  pol 0, ps 2 -> 984 of 1024
        32'hC812_0320   // cmp 200, pol 1, ps 2 -> 800 of 1024
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        #1;
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
    endtask

    task automatic wait_rise(input int lim, output int waited);
        logic prev;
        prev = pwm_out;
        waited = 0;
        while (waited < lim) begin
            @(negedge clk);
            waited++;
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end
    endtask

    function automatic logic [31:0] word(input logic [7:0] c, input logic p, input logic [3:0] s);
        return {16'h0, c, 3'b000, p, s};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hi;
        int w;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R1 out in reset", int'(pwm_out), 0);
        check(reg_rdata == 32'h0, "R1 rdata in reset", int'(reg_rdata), 0);
        @(negedge clk); rst = 1'b0;
        repeat (4) @(negedge clk);
        // R8 idle after reset: pol 0, cmp 0 -> always high
        count_high(256, hi);
        check(hi == 256, "R8 idle inverted level", hi, 256);

        // R2 layout, unused bits read zero
        bus_write(4'h0, 32'hFFFF_A5E1);
        check(reg_rdata == 32'h0000_A501, "R2 readback fields", int'(reg_rdata), 32'hA501);
        bus_write(4'h3, 32'h0000_1234);
        check(reg_rdata == 32'h0000_A501, "R2 other address write ignored", int'(reg_rdata), 32'hA501);
        reg_addr = 4'h3; #1;
        check(reg_rdata == 32'h0, "R2 other address reads zero", int'(reg_rdata), 0);
        reg_addr = 4'h0; #1;

        // R3 lock blocks the register
        wr_lock = 1'b1;
        bus_write(4'h0, 32'h0000_FF13);
        check(reg_rdata == 32'h0000_A501, "R3 locked write ignored", int'(reg_rdata), 32'hA501);
        wr_lock = 1'b0;

        // Vector table: R4 R6 R7 R8
        for (int i = 0; i < 8; i++) begin
            logic [7:0]  c;
            logic        p;
            logic [3:0]  s;
            int          exp_hi;
            c = VEC[i][31:24];
            p = VEC[i][20];
            s = VEC[i][19:16];
            exp_hi = int'(VEC[i][15:0]);
            bus_write(4'h0, word(c, p, s));
            check(reg_rdata == word(c, p, s), "R2 vector readback", int'(reg_rdata), int'(word(c, p, s)));
            repeat (1024 + (256 << s) + 8) @(negedge clk);
            count_high(256 << s, hi);
            check(hi == exp_hi, p ? "R4 R6 R8 active-high width" : "R4 R7 R8 active-low width", hi, exp_hi);
        end

        // R3 lock leaves the waveform unchanged (cmp 200, pol 1, ps 2 stays)
        wr_lock = 1'b1;
        bus_write(4'h0, word(8'd0, 1'b1, 4'd0));
        repeat (2100) @(negedge clk);
        count_high(1024, hi);
        check(hi == 800, "R3 locked waveform", hi, 800);
        wr_lock = 1'b0;

        // R5 period of 256 cycles at divide by 1
        bus_write(4'h0, word(8'd64, 1'b1, 4'd0));
        repeat (1100) @(negedge clk);
        wait_rise(300, w);
        wait_rise(300, w);
        check(w == 256, "R5 period length", w, 256);

        // R9 deferred load, R10 prescaler restart, R4 divide by 32768
        bus_write(4'h0, word(8'd0, 1'b1, 4'd0));
        repeat (300) @(negedge clk);
        check(pwm_out == 1'b0, "R8 cmp zero idle low", int'(pwm_out), 0);
        bus_write(4'h0, word(8'd1, 1'b1, 4'd15));
        check(pwm_out == 1'b0, "R9 old setting kept", int'(pwm_out), 0);
        wait_rise(300, w);
        check(pwm_out == 1'b1 && w <= 257, "R9 applied at wrap", w, 257);
        hi = 0;
        while (pwm_out && hi < 40000) begin
            @(negedge clk);
            hi++;
        end
        check(hi == 32768, "R10 R4 first step length", hi, 32768);

        // R1 reset again
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        check(pwm_out == 1'b0, "R1 out in second reset", int'(pwm_out), 0);
        check(reg_rdata == 32'h0, "R1 word cleared", int'(reg_rdata), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule